// File: doc/BRIEF.md
# Serial Frame Receiver with Mode Register

This block is a write-only serial slave. It has a select line, which is active high, a serial clock and a data line. While select is high, the block takes one data bit on every falling edge of the serial clock, most significant bit first. When select drops, the block sorts the frame by the number of clock edges it counted. An 8-edge frame loads an 8-bit mode register. A 16-edge frame becomes a data word for a sigma-delta DAC. A frame of any other length leaves every register as it was.

All three serial inputs are brought into the system clock domain through synchronisers, and edges are detected there. The serial clock must therefore run well below the system clock. The DAC word leaves on a valid/ready interface:

- `dac_valid_o` rises with a new word, and it and `dac_word_o` stay unchanged until the cycle in which `dac_ready_i` is also high.
- A 16-edge frame that ends while a word is still waiting is dropped.

Mode bit 0 chooses the DAC word length and mode bit 6 chooses the output format. Both are also given out on their own pins.

Top module: `spi_mode_rx`

## Requirements
- R1: Reset clears the mode register to 0x00 and drives `dac_valid_o`, `dac_wide_o` and `dac_nrz_o` low.
- R2: Bits are sampled on the falling edge of `sclk_i` while `sel_i` is high. The first bit sampled is the most significant bit of the frame.
- R3: A frame of exactly 8 falling edges loads `mode_o` on the third rising `clk` edge after `sel_i` falls, and not before.
- R4: `dac_wide_o` equals mode bit 0 (1 = 16-bit words, 0 = 14-bit words). `dac_nrz_o` equals mode bit 6 (1 = non-return-to-zero, 0 = return-to-zero).
- R5: In 16-bit mode, a 16-edge frame is presented unchanged on `dac_word_o`, and `dac_valid_o` rises on the third rising `clk` edge after `sel_i` falls.
- R6: In 14-bit mode, a 16-edge frame whose two most significant bits are zero is presented as its low 14 bits shifted left by two. A 16-edge frame with either of those two bits set is dropped.
- R7: A frame of any length other than 8 or 16, including zero edges, changes neither `mode_o` nor `dac_valid_o`. The edge count saturates, so a 40-edge frame is not taken as an 8-edge frame.
- R8: While `dac_valid_o` is high and `dac_ready_i` is low, `dac_valid_o` stays high and `dac_word_o` stays stable. After a cycle in which both are high, `dac_valid_o` is low.
- R9: A 16-edge frame that ends while a word is pending is dropped, and the pending word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Frame select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, changes on the rising edge of `sclk_i` |
| mode_o | output | 8 | Mode register |
| dac_wide_o | output | 1 | DAC word length, 1 = 16 bits |
| dac_nrz_o | output | 1 | DAC output format, 1 = non-return-to-zero |
| dac_valid_o | output | 1 | DAC word valid |
| dac_ready_i | input | 1 | DAC word accepted |
| dac_word_o | output | 16 | DAC data word |

## Verification
Both the mode register and the DAC word are due on the third rising system-clock edge after the select pin falls. That delay is two synchroniser stages and one edge-detect register. The bench changes its inputs on falling clock edges, counts exactly three rising edges after it drops select, and samples on the next falling edge. One directed check samples one edge earlier and expects the old value. A handshake clears the valid on the rising edge on which ready is seen high, so the bench holds ready high for one rising edge and checks on the falling edge that follows.

// File: rtl/spi_mode_rx_pkg.sv
package spi_mode_rx_pkg;
  // classification of a completed frame by its edge count
  typedef enum logic [1:0] {
    FRM_DROP = 2'd0,
    FRM_MODE = 2'd1,
    FRM_WORD = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/spi_mode_rx_sync.sv
module spi_mode_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign level_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_mode_rx_shift.sv
module spi_mode_rx_shift #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sclk_lvl,
  input  logic              sdata_lvl,
  output logic              frame_end,
  output logic [CNT_W-1:0]  edge_cnt,
  output logic [WORD_W-1:0] shreg
);
  logic sel_prev, sclk_prev;
  logic sel_rise, sclk_fall;

  assign sel_rise  = sel_lvl & ~sel_prev;
  assign frame_end = ~sel_lvl & sel_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      sel_prev  <= sel_lvl;
      sclk_prev <= sclk_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      shreg    <= '0;
    end else if (sel_rise) begin
      edge_cnt <= '0;
    end else if (sel_lvl && sclk_fall) begin
      shreg <= {shreg[WORD_W-2:0], sdata_lvl};
      if (edge_cnt != '1) edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_mode_rx_dispatch.sv
module spi_mode_rx_dispatch
  import spi_mode_rx_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int WORD_W   = 16,
  parameter int SHORT_W  = 14,
  parameter int CNT_W    = 5,
  parameter int WIDE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  edge_cnt,
  input  logic [WORD_W-1:0] shreg,
  input  logic              ready_i,
  output logic [MODE_W-1:0] mode_q,
  output logic              valid_q,
  output logic [WORD_W-1:0] word_q
);
  localparam int PAD_W = WORD_W - SHORT_W;

  frame_kind_e kind;
  logic        wide, pad_clear, take_word;
  logic [WORD_W-1:0] word_next;

  assign wide      = mode_q[WIDE_BIT];
  assign pad_clear = (shreg[WORD_W-1:SHORT_W] == '0);
  assign word_next = wide ? shreg : {shreg[SHORT_W-1:0], {PAD_W{1'b0}}};

  always_comb begin
    kind = FRM_DROP;
    if (edge_cnt == CNT_W'(MODE_W))      kind = FRM_MODE;
    else if (edge_cnt == CNT_W'(WORD_W)) kind = FRM_WORD;
  end

  assign take_word = frame_end && (kind == FRM_WORD) && (wide || pad_clear) && !valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mode_q <= '0;
    else if (frame_end && kind == FRM_MODE) mode_q <= shreg[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end else if (take_word) begin
      valid_q <= 1'b1;
      word_q  <= word_next;
    end
  end
endmodule

// File: rtl/spi_mode_rx.sv
module spi_mode_rx #(
  parameter int MODE_W      = 8,
  parameter int WORD_W      = 16,
  parameter int SHORT_W     = 14,
  parameter int SYNC_STAGES = 2,
  parameter int WIDE_BIT    = 0,
  parameter int NRZ_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              dac_wide_o,
  output logic              dac_nrz_o,
  output logic              dac_valid_o,
  input  logic              dac_ready_i,
  output logic [WORD_W-1:0] dac_word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2) + 1;

  logic [2:0]        lvl;
  logic              frame_end;
  logic [CNT_W-1:0]  edge_cnt;
  logic [WORD_W-1:0] shreg;

  spi_mode_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sdata_i, sclk_i, sel_i}),
    .level_o(lvl)
  );

  spi_mode_rx_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(lvl[0]), .sclk_lvl(lvl[1]), .sdata_lvl(lvl[2]),
    .frame_end(frame_end), .edge_cnt(edge_cnt), .shreg(shreg)
  );

  spi_mode_rx_dispatch #(
    .MODE_W(MODE_W), .WORD_W(WORD_W), .SHORT_W(SHORT_W),
    .CNT_W(CNT_W), .WIDE_BIT(WIDE_BIT)
  ) u_disp (
    .clk(clk), .rst_n(rst_n),
    .frame_end(frame_end), .edge_cnt(edge_cnt), .shreg(shreg),
    .ready_i(dac_ready_i),
    .mode_q(mode_o), .valid_q(dac_valid_o), .word_q(dac_word_o)
  );

  assign dac_wide_o = mode_o[WIDE_BIT];
  assign dac_nrz_o  = mode_o[NRZ_BIT];
endmodule

// File: rtl/spi_mode_rx_chk.sv
module spi_mode_rx_chk #(
  parameter int MODE_W   = 8,
  parameter int WORD_W   = 16,
  parameter int SHORT_W  = 14,
  parameter int WIDE_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic [MODE_W-1:0] mode,
  input logic              valid,
  input logic              ready,
  input logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - SHORT_W;

  // R3
  mode_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(mode));

  // R5
  valid_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(frame_end));

  // R6
  short_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) && !mode[WIDE_BIT] |-> word[PAD_W-1:0] == '0);

  // R8
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(word));

  // R8
  clear_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> !valid);
endmodule

bind spi_mode_rx spi_mode_rx_chk #(
  .MODE_W(MODE_W), .WORD_W(WORD_W), .SHORT_W(SHORT_W), .WIDE_BIT(WIDE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .mode(mode_o),
  .valid(dac_valid_o), .ready(dac_ready_i), .word(dac_word_o)
);

// File: tb/spi_mode_rx_tb.sv
`timescale 1ns/1ps
module spi_mode_rx_tb;
  localparam int HALF = 4;
  localparam int NV   = 13;
  // {len[5:0], data[15:0], kind[1:0] (0 none,1 mode,2 word), expected[15:0]}
  localparam logic [39:0] VEC [NV] = '{
    {6'd8,  16'h00A5, 2'd1, 16'h00A5},   // R2 mode write, wide
    {6'd16, 16'hBEEF, 2'd2, 16'hBEEF},   // R5
    {6'd8,  16'h0040, 2'd1, 16'h0040},   // R4 short, nrz
    {6'd16, 16'h1234, 2'd2, 16'h48D0},   // R6
    {6'd16, 16'h8001, 2'd0, 16'h0000},   // R6 bad pad
    {6'd16, 16'h4000, 2'd0, 16'h0000},   // R6 bad pad
    {6'd12, 16'h0FFF, 2'd0, 16'h0000},   // R7
    {6'd40, 16'h00FF, 2'd0, 16'h0000},   // R7 saturation
    {6'd7,  16'h007F, 2'd0, 16'h0000},   // R7
    {6'd16, 16'h3FFF, 2'd2, 16'hFFFC},   // R6
    {6'd8,  16'h0001, 2'd1, 16'h0001},   // R4 wide
    {6'd16, 16'h0000, 2'd2, 16'h0000},   // R5
    {6'd0,  16'h0000, 2'd0, 16'h0000}    // R7 empty
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdata = 1'b0, ready = 1'b0;
  logic [7:0]  mode;
  logic        wide, nrz, valid;
  logic [15:0] word;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_mode = 8'h00;
  logic [5:0] vlen;
  logic [15:0] vdata, vexp;
  logic [1:0] vkind;

  always #2.5 clk = ~clk;

  spi_mode_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdata_i(sdata),
    .mode_o(mode), .dac_wide_o(wide), .dac_nrz_o(nrz),
    .dac_valid_o(valid), .dac_ready_i(ready), .dac_word_o(word)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [39:0] bits);
    @(negedge clk) sel = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      sclk = 1'b1; sdata = bits[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sel = 1'b0;
  endtask

  task automatic wait_due();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic accept();
    ready = 1'b1;
    @(posedge clk);
    @(negedge clk) ready = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 mode", {8'h00, mode}, 16'h0000);
    chk("R1 valid", {15'd0, valid}, 16'h0000);
    chk("R1 wide/nrz", {14'd0, wide, nrz}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vlen = VEC[i][39:34]; vdata = VEC[i][33:18];
      vkind = VEC[i][17:16]; vexp = VEC[i][15:0];
      send_frame(int'(vlen), {24'd0, vdata});
      wait_due();
      if (vkind == 2'd1) begin
        exp_mode = vexp[7:0];
        chk("R2 R3 mode value", {8'h00, mode}, vexp);
        chk("R4 wide/nrz pins", {14'd0, wide, nrz}, {14'd0, exp_mode[0], exp_mode[6]});
      end else if (vkind == 2'd2) begin
        chk("R5 R6 valid", {15'd0, valid}, 16'h0001);
        chk("R5 R6 word", word, vexp);
        accept();
        chk("R8 valid after accept", {15'd0, valid}, 16'h0000);
      end else begin
        chk("R6 R7 mode kept", {8'h00, mode}, {8'h00, exp_mode});
        chk("R6 R7 no word", {15'd0, valid}, 16'h0000);
      end
    end

    // R3 latency: still old value one edge early
    send_frame(8, 40'h5A);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 not yet updated", {8'h00, mode}, 16'h0001);
    @(posedge clk);
    @(negedge clk);
    chk("R3 updated on third edge", {8'h00, mode}, 16'h005A);
    chk("R4 pins after 5A", {14'd0, wide, nrz}, 16'h0001);

    // R8 R9 back-pressure and drop while pending
    send_frame(8, 40'h01);
    wait_due();
    send_frame(16, 40'hAAAA);
    wait_due();
    chk("R8 valid pending", {15'd0, valid}, 16'h0001);
    repeat (10) @(negedge clk);
    chk("R8 word held", word, 16'hAAAA);
    send_frame(16, 40'h5555);
    wait_due();
    chk("R9 pending word kept", word, 16'hAAAA);
    chk("R9 valid still high", {15'd0, valid}, 16'h0001);
    accept();
    chk("R9 dropped frame not delivered", {15'd0, valid}, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R9 still no word", {15'd0, valid}, 16'h0000);

    // R1 reset in operation
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mode after reset", {8'h00, mode}, 16'h0000);
    chk("R1 pins after reset", {14'd0, wide, nrz}, 16'h0000);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule